// File: doc/BRIEF.md
# Slow Clock Frequency Calibration Counter

This block measures one of three low-frequency clocks against the fast reference clock it runs on. A measurement window spans a programmed number of slow-clock cycles, and the block counts how many reference cycles pass inside that window. The result tells software the slow clock's true period in reference cycles.

The slow clocks enter as plain inputs. Each one is brought into the reference domain through a synchronizer and a rising-edge detector, and a run-time selector picks which detected edge stream drives the window. Two operating modes exist. In single-shot mode, a rising edge on the start input launches one window, and a ready flag rises when that window closes. In continuous mode, windows follow one another with no gap, and the result register is refreshed at the close of each one. The result register changes only when a window closes, so a read never returns a partial count.

Top module: `slowclk_cal_counter`

## Requirements
- R1: While reset is applied, `ready` is 0 and `cal_value` is 0. The internal reset is released on the second `clk_ref` rising edge after `rst_ref_n` rises. The first edge that runs the logic is the third.
- R2: Each slow input passes through a two-flop synchronizer and then a rising-edge detector. `src_sel` encoding: 0 selects `slow_mux_i`, 1 selects `slow_xtal32k_i`, 2 selects `slow_oscdiv_i`, and 3 behaves exactly like 0.
- R3: A window opens on a detected slow rising edge and closes on the detected edge N later, where N is the effective window length. The result is the number of reference cycles between those two edges, so a slow clock with a steady period of P reference cycles gives N*P. `ready` and `cal_value` change on the clock edge where the closing slow edge is detected.
- R4: A `win_len` of 0 is treated as a window of one slow cycle.
- R5: A single-shot measurement starts only on a 0-to-1 change of `oneshot_start` as sampled on `clk_ref`. That same edge clears `ready`, so `ready` reads 0 in the following cycle. Holding `oneshot_start` high starts nothing further.
- R6: In single-shot mode, a closing window sets `ready` to 1 and loads `cal_value` once. After that, `cal_value` does not change until the next start, even if the source select or the window length is changed.
- R7: In continuous mode (`cont_en`=1), windows run back to back and `cal_value` is refreshed at the close of each window. Once `ready` is set, it stays 1 until a start edge clears it.
- R8: Coming out of reset, the engine is already armed. With `cont_en` high, windows run and `ready` rises without any start command.
- R9: The reference count saturates at 2^CNT_W-1 and does not wrap.
- R10: If a start edge falls in the same cycle as a window close, the start wins. The closing window is discarded: `ready` goes to 0, `cal_value` keeps its old value, and a new window opens on the next slow edge after that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Fast reference clock |
| rst_ref_n | input | 1 | Asynchronous active-low reset |
| slow_mux_i | input | 1 | Slow clock from the slow-clock selector output |
| slow_xtal32k_i | input | 1 | 32 kHz crystal slow clock |
| slow_oscdiv_i | input | 1 | 8 MHz oscillator divided by 256 |
| src_sel | input | 2 | Slow source select |
| win_len | input | WIN_W | Window length in slow cycles |
| oneshot_start | input | 1 | Single-shot start, acts on its rising edge |
| cont_en | input | 1 | Continuous-mode enable |
| ready | output | 1 | Measurement complete flag |
| cal_value | output | CNT_W | Reference cycles counted in the last completed window |

## Verification
A start edge can arrive in the very cycle that a running window closes. The bench provokes this in continuous mode. It waits for `ready` to rise, which marks a window close. It then knows the next close falls exactly one window later, so it schedules the start rising edge to be sampled on that edge. The outcome is judged three ways. First, `ready` must read 0 right after the collision. Second, `ready` must still be 0 at the point where an uninterrupted continuous run would have closed again. Third, the window that finally closes must hold the full expected count. A cycle-accurate behavioural model also counts the collision and checks both outputs on every clock.

// File: rtl/slowcal_pkg.sv
package slowcal_pkg;
  localparam int NUM_SRC = 3;

  typedef enum logic [1:0] {
    SRC_MUX    = 2'd0,
    SRC_XTAL32 = 2'd1,
    SRC_OSCDIV = 2'd2,
    SRC_ALIAS  = 2'd3
  } slow_src_e;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_ARM  = 2'd1,
    ENG_RUN  = 2'd2
  } eng_state_e;
endpackage

// File: rtl/slowcal_rst_sync.sv
module slowcal_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  output logic rst_out_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_in_n) begin
    if (!rst_in_n) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_out_n = chain_q[STAGES-1];
endmodule

// File: rtl/slowcal_edge_sync.sv
module slowcal_edge_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  localparam int LAST = SYNC_STAGES;

  logic [LAST:0] pipe_q;
  logic [LAST:0] pipe_d;

  always_comb begin
    pipe_d = {pipe_q[LAST-1:0], async_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe_q <= '0;
    else        pipe_q <= pipe_d;
  end

  assign rise = pipe_q[LAST-1] & ~pipe_q[LAST];
endmodule

// File: rtl/slowcal_window_engine.sv
module slowcal_window_engine
  import slowcal_pkg::*;
#(
  parameter int CNT_W = 20,
  parameter int WIN_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             slow_rise,
  input  logic             start_lvl,
  input  logic             cont_en,
  input  logic [WIN_W-1:0] win_len,
  output logic             ready,
  output logic [CNT_W-1:0] value
);
  localparam logic [CNT_W-1:0] REF_MAX = {CNT_W{1'b1}};
  localparam logic [WIN_W-1:0] WIN_ONE = {{(WIN_W-1){1'b0}}, 1'b1};

  eng_state_e       state_q, state_d;
  logic [CNT_W-1:0] ref_q, ref_d, ref_inc;
  logic [WIN_W:0]   slow_q, slow_d, slow_inc;
  logic [WIN_W-1:0] eff_win;
  logic             start_q;
  logic             start_rise;
  logic             win_close;
  logic             ready_q, ready_d;
  logic [CNT_W-1:0] value_q, value_d;
  logic             value_en;

  always_comb begin
    eff_win    = (win_len == '0) ? WIN_ONE : win_len;
    ref_inc    = (ref_q == REF_MAX) ? REF_MAX : ref_q + 1'b1;
    slow_inc   = slow_q + 1'b1;
    start_rise = start_lvl & ~start_q;
    win_close  = (state_q == ENG_RUN) && slow_rise && (slow_inc >= {1'b0, eff_win});

    state_d  = state_q;
    ref_d    = ref_q;
    slow_d   = slow_q;
    ready_d  = ready_q;
    value_d  = ref_inc;
    value_en = 1'b0;

    unique case (state_q)
      ENG_IDLE: begin
        if (cont_en) state_d = ENG_ARM;
      end
      ENG_ARM: begin
        if (slow_rise) begin
          state_d = ENG_RUN;
          ref_d   = '0;
          slow_d  = '0;
        end
      end
      default: begin
        ref_d = ref_inc;
        if (slow_rise) slow_d = slow_inc;
        if (win_close) begin
          value_en = 1'b1;
          ready_d  = 1'b1;
          ref_d    = '0;
          slow_d   = '0;
          state_d  = cont_en ? ENG_RUN : ENG_IDLE;
        end
      end
    endcase

    if (start_rise) begin
      state_d  = ENG_ARM;
      ready_d  = 1'b0;
      value_en = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ENG_ARM;
      ref_q   <= '0;
      slow_q  <= '0;
      start_q <= 1'b0;
      ready_q <= 1'b0;
    end else begin
      state_q <= state_d;
      ref_q   <= ref_d;
      slow_q  <= slow_d;
      start_q <= start_lvl;
      ready_q <= ready_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value_q <= '0;
    else if (value_en) value_q <= value_d;
  end

  assign ready = ready_q;
  assign value = value_q;
endmodule

// File: rtl/slowclk_cal_counter.sv
module slowclk_cal_counter
  import slowcal_pkg::*;
#(
  parameter int CNT_W       = 20,
  parameter int WIN_W       = 15,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_ref,
  input  logic             rst_ref_n,
  input  logic             slow_mux_i,
  input  logic             slow_xtal32k_i,
  input  logic             slow_oscdiv_i,
  input  logic [1:0]       src_sel,
  input  logic [WIN_W-1:0] win_len,
  input  logic             oneshot_start,
  input  logic             cont_en,
  output logic             ready,
  output logic [CNT_W-1:0] cal_value
);
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] slow_vec;
  logic [NUM_SRC-1:0] rise_vec;
  logic               sel_rise;

  assign slow_vec = {slow_oscdiv_i, slow_xtal32k_i, slow_mux_i};

  slowcal_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk       (clk_ref),
    .rst_in_n  (rst_ref_n),
    .rst_out_n (rst_sync_n)
  );

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    slowcal_edge_sync #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk      (clk_ref),
      .rst_n    (rst_sync_n),
      .async_in (slow_vec[g]),
      .rise     (rise_vec[g])
    );
  end

  always_comb begin
    unique case (slow_src_e'(src_sel))
      SRC_XTAL32: sel_rise = rise_vec[1];
      SRC_OSCDIV: sel_rise = rise_vec[2];
      default:    sel_rise = rise_vec[0];
    endcase
  end

  slowcal_window_engine #(.CNT_W(CNT_W), .WIN_W(WIN_W)) u_engine (
    .clk       (clk_ref),
    .rst_n     (rst_sync_n),
    .slow_rise (sel_rise),
    .start_lvl (oneshot_start),
    .cont_en   (cont_en),
    .win_len   (win_len),
    .ready     (ready),
    .value     (cal_value)
  );
endmodule

// File: rtl/slowclk_cal_counter_chk.sv
module slowclk_cal_counter_chk #(
  parameter int CNT_W = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             ready,
  input logic [CNT_W-1:0] value,
  input logic             sel_rise
);
  // R5: a start edge clears ready in the next cycle
  a_r5_start_clears_ready: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start) |=> !ready);

  // R5: ready only falls one cycle after a start edge
  a_r5_ready_falls_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> ($past(start) && !$past(start, 2)));

  // R6: the result register changes only when a window closes
  a_r6_value_only_at_close: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(value) |-> ready);

  // R3: a window closes only on a detected slow edge
  a_r3_close_on_slow_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ready) |-> $past(sel_rise));
endmodule

bind slowclk_cal_counter slowclk_cal_counter_chk #(.CNT_W(CNT_W)) u_chk (
  .clk      (clk_ref),
  .rst_n    (rst_sync_n),
  .start    (oneshot_start),
  .ready    (ready),
  .value    (cal_value),
  .sel_rise (sel_rise)
);

// File: tb/tb_slowclk_cal_counter.sv
module tb_slowclk_cal_counter;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;
  localparam int WIN_W = 6;
  localparam int P_MUX = 10;
  localparam int P_XT  = 14;
  localparam int P_OSC = 6;
  localparam int MAXV  = (1 << CNT_W) - 1;

  logic             clk_ref = 1'b0;
  logic             rst_ref_n;
  logic             slow_mux_i, slow_xtal32k_i, slow_oscdiv_i;
  logic [1:0]       src_sel;
  logic [WIN_W-1:0] win_len;
  logic             oneshot_start;
  logic             cont_en;
  logic             ready;
  logic [CNT_W-1:0] cal_value;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  bit finished = 1'b0;

  slowclk_cal_counter #(.CNT_W(CNT_W), .WIN_W(WIN_W)) dut (
    .clk_ref(clk_ref), .rst_ref_n(rst_ref_n),
    .slow_mux_i(slow_mux_i), .slow_xtal32k_i(slow_xtal32k_i), .slow_oscdiv_i(slow_oscdiv_i),
    .src_sel(src_sel), .win_len(win_len), .oneshot_start(oneshot_start),
    .cont_en(cont_en), .ready(ready), .cal_value(cal_value)
  );

  always #(CLK_PERIOD/2) clk_ref = ~clk_ref;

  // slow clocks, changed away from the active edge
  initial begin
    slow_mux_i = 0; slow_xtal32k_i = 0; slow_oscdiv_i = 0;
    forever begin
      @(negedge clk_ref);
      cyc++;
      slow_mux_i     = (cyc % P_MUX) < P_MUX/2;
      slow_xtal32k_i = (cyc % P_XT)  < P_XT/2;
      slow_oscdiv_i  = (cyc % P_OSC) < P_OSC/2;
    end
  end

  // behavioural reference model
  int m_rs, m_state, m_ref, m_slow, m_val, collisions;
  bit m_ready, m_sq;
  bit h[3][3];

  task automatic model_reset();
    for (int i = 0; i < 3; i++) for (int j = 0; j < 3; j++) h[i][j] = 0;
    m_sq = 0; m_state = 1; m_ref = 0; m_slow = 0; m_ready = 0; m_val = 0;
  endtask

  always @(posedge clk_ref or negedge rst_ref_n) begin
    if (!rst_ref_n) begin
      m_rs = 0; model_reset();
    end else if (m_rs < 2) begin
      m_rs++; model_reset();
    end else begin
      bit r[3];
      bit in_s[3];
      bit e, sr, done;
      int eff, nref;
      in_s[0] = slow_mux_i; in_s[1] = slow_xtal32k_i; in_s[2] = slow_oscdiv_i;
      for (int i = 0; i < 3; i++) begin
        r[i] = h[i][1] & ~h[i][2];
        h[i][2] = h[i][1]; h[i][1] = h[i][0]; h[i][0] = in_s[i];
      end
      e = (src_sel == 2'd1) ? r[1] : (src_sel == 2'd2) ? r[2] : r[0];
      sr = oneshot_start & ~m_sq;
      m_sq = oneshot_start;
      eff = (win_len == 0) ? 1 : int'(win_len);
      done = 0;
      if (m_state == 0) begin
        if (cont_en) m_state = 1;
      end else if (m_state == 1) begin
        if (e) begin m_state = 2; m_ref = 0; m_slow = 0; end
      end else begin
        nref = (m_ref + 1 > MAXV) ? MAXV : m_ref + 1;
        if (e && (m_slow + 1 >= eff)) begin
          done = 1;
          if (!sr) begin m_val = nref; m_ready = 1; end
          m_ref = 0; m_slow = 0;
          m_state = cont_en ? 2 : 0;
        end else begin
          m_ref = nref;
          if (e) m_slow++;
        end
      end
      if (sr) begin
        if (done) collisions++;
        m_state = 1; m_ready = 0;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk_ref) begin
    if (!finished) begin
      check("R3 R7 model ready", int'(ready), int'(m_ready));
      check("R3 R9 model value", int'(cal_value), m_val);
    end
  end

  task automatic wait_ready(string tag);
    int n = 0;
    while (!ready && n < 2000) begin @(negedge clk_ref); n++; end
    if (!ready) check(tag, 0, 1);
  endtask

  task automatic launch();
    oneshot_start = 0;
    @(negedge clk_ref);
    oneshot_start = 1;
    @(negedge clk_ref);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_ref);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    collisions = 0;
    rst_ref_n = 0; src_sel = 2'd0; win_len = 6'd4; oneshot_start = 0; cont_en = 1;
    repeat (5) @(negedge clk_ref);
    check("R1 reset ready", int'(ready), 0);
    check("R1 reset value", int'(cal_value), 0);
    rst_ref_n = 1;

    // R8: armed after reset, continuous windows without a start
    wait_ready("R8 ready after reset");
    check("R8 R3 first window", int'(cal_value), 4 * P_MUX);
    repeat (40) @(negedge clk_ref);
    check("R7 ready held", int'(ready), 1);
    check("R7 value repeat", int'(cal_value), 4 * P_MUX);
    win_len = 6'd2;
    repeat (60) @(negedge clk_ref);
    check("R7 value refreshed", int'(cal_value), 2 * P_MUX);

    // single shot on the crystal source
    cont_en = 0; src_sel = 2'd1; win_len = 6'd3;
    repeat (30) @(negedge clk_ref);
    launch();
    check("R5 ready cleared", int'(ready), 0);
    wait_ready("R6 single shot done");
    check("R2 R3 xtal value", int'(cal_value), 3 * P_XT);
    src_sel = 2'd2;
    repeat (100) @(negedge clk_ref);
    check("R5 held start no relaunch", int'(ready), 1);
    check("R6 value frozen", int'(cal_value), 3 * P_XT);

    win_len = 6'd5;
    launch();
    wait_ready("R2 osc done");
    check("R2 osc value", int'(cal_value), 5 * P_OSC);

    src_sel = 2'd3; win_len = 6'd1;
    launch();
    wait_ready("R2 alias done");
    check("R2 select 3 as mux", int'(cal_value), P_MUX);

    src_sel = 2'd2; win_len = 6'd0;
    launch();
    wait_ready("R4 zero window done");
    check("R4 zero window", int'(cal_value), P_OSC);

    src_sel = 2'd1; win_len = 6'd20;
    launch();
    wait_ready("R9 long window done");
    check("R9 saturated", int'(cal_value), MAXV);

    // R10: start edge on the same cycle as a continuous window close
    cont_en = 1; src_sel = 2'd2; win_len = 6'd2;
    launch();
    wait_ready("R10 first close");
    check("R10 base value", int'(cal_value), 2 * P_OSC);
    oneshot_start = 0;
    repeat (11) @(negedge clk_ref);
    oneshot_start = 1;
    @(negedge clk_ref);
    check("R10 start wins ready", int'(ready), 0);
    check("R10 value kept", int'(cal_value), 2 * P_OSC);
    repeat (12) @(negedge clk_ref);
    check("R10 window restarted", int'(ready), 0);
    wait_ready("R10 next close");
    check("R10 next value", int'(cal_value), 2 * P_OSC);
    check("R10 collision seen", int'(collisions > 0), 1);

    repeat (5) @(negedge clk_ref);
    finish_run();
  end
endmodule